// File: doc/BRIEF.md
# Destination Address Filter with Setup-Frame Loader

This block decides whether a received Ethernet frame is kept, based on its 48-bit destination address. It holds a table of sixteen exact-match addresses. Software fills the table by streaming a setup frame into the block one byte at a time. The frame is framed by a start strobe, a per-byte valid and an end strobe. Only a frame of exactly the expected length replaces the table. Anything shorter, longer or unframed is thrown away.

For every address presented with its valid strobe, the block returns a registered verdict one cycle later. The verdict is an accept bit plus two flags: one marks a frame that passed only because filtering was bypassed, the other marks a frame that passed only because it is multicast. Four mode inputs set the policy: promiscuous, receive-all, pass-all-multicast and inverse matching. The decision is an ordered chain in which broadcast takes precedence over everything else.

Top module: `dest_addr_filter`

## Requirements
- R1: Reset clears every table entry to all zeros, so after reset, with all modes off, the all-zero address is accepted and any address that is not broadcast, not all-zero and has bit 0 of byte 0 clear is rejected.
- R2: Address byte k sits on `addr[8k+7:8k]`, and byte 0 is the first byte on the wire. Table entry n takes its bytes 0..5 from setup-frame offsets 12n+0, 12n+1, 12n+4, 12n+5, 12n+8, 12n+9, counting from the byte taken with the start strobe as offset 0. The other six bytes of each 12-byte group have no effect.
- R3: A setup frame replaces the table only when exactly 192 bytes were taken between the start strobe and the end strobe, inclusive of a byte valid in either strobe cycle. Any other count leaves the table unchanged. A new table is used for addresses presented from the second cycle after the end strobe onward.
- R4: Bytes and end strobes that arrive with no frame open (no start since the last end) have no effect on the table. A start strobe during an open frame restarts the byte count at zero.
- R5: The all-ones address is accepted in every mode, with both flags low.
- R6: Otherwise, if promiscuous or receive-all mode is on, the address is accepted and `filter_fail` is raised, with `multicast_hit` low.
- R7: Otherwise, if pass-all-multicast is on and `addr[0]` is 1, the address is accepted and `multicast_hit` is raised, with `filter_fail` low.
- R8: Otherwise, `accept` equals "some table entry equals the address", inverted when inverse mode is on, with both flags low.
- R9: `result_valid` is `addr_valid` delayed by one clock, and `accept` and both flags are low in any cycle where `result_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_start | input | 1 | Opens a setup frame; the byte in this cycle is offset 0 |
| setup_valid | input | 1 | `setup_data` carries a byte this cycle |
| setup_data | input | 8 | Setup-frame byte |
| setup_end | input | 1 | Closes the open setup frame; a byte valid this cycle counts |
| addr_valid | input | 1 | A destination address is presented |
| addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| mode_promisc | input | 1 | Promiscuous mode |
| mode_rx_all | input | 1 | Receive-all mode |
| mode_all_multi | input | 1 | Pass all multicast addresses |
| mode_inverse | input | 1 | Invert the table-match result |
| result_valid | output | 1 | Verdict valid, one cycle after `addr_valid` |
| accept | output | 1 | Frame accepted |
| filter_fail | output | 1 | Accepted only because filtering was bypassed |
| multicast_hit | output | 1 | Accepted only as a multicast address |

## Verification
The hardest state to reach from the ports is a table whose contents tell apart the six used byte slots of each 12-byte group from the six unused ones. Every one of the sixteen entries must hold a distinct address, and the filler slots must hold values that would form valid-looking addresses of their own. The bench streams setup frames with one arithmetic pattern in the used slots and a different one in the filler. It then presents each stored address, a one-bit neighbour of it, and the address built from the filler, all under all sixteen mode combinations. Frames of 191 and 193 bytes, an unframed 192-byte burst, and a restarted frame follow. Each of these is checked to see whether the previous table survived.

// File: rtl/daf_pkg.sv
// Package: shared types of the destination address filter.
// Assumes: nothing beyond IEEE 1800-2017.
package daf_pkg;

    // Filtering policy selected by the mode inputs.
    typedef struct packed {
        logic promisc;
        logic rx_all;
        logic all_multi;
        logic inverse;
    } daf_mode_t;

    // Registered outcome for one presented address.
    typedef struct packed {
        logic accept;
        logic filt_fail;
        logic mcast;
    } daf_verdict_t;

    // Setup-frame offset, within an entry's group, of address byte k:
    // the group is read as pairs of bytes with a two-byte gap after each pair.
    function automatic int unsigned slot_offset(input int unsigned k);
        return (k / 2) * 4 + (k % 2);
    endfunction

endpackage

// File: rtl/daf_setup_loader.sv
// Module: daf_setup_loader
// Captures a byte-streamed setup frame into a staging image of the table
// and raises a one-cycle commit pulse, one clock after the end strobe, when
// the frame held exactly N_ENTRY*GROUP_BYTES bytes.
// Assumes: a byte valid in the start or end cycle belongs to the frame;
// bytes outside an open frame are dropped; the count saturates past the
// expected length, so an over-long frame can never look complete.
module daf_setup_loader
    import daf_pkg::*;
#(
    parameter int N_ENTRY     = 16,
    parameter int ADDR_BYTES  = 6,
    parameter int GROUP_BYTES = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_start,
    input  logic                          byte_valid,
    input  logic [7:0]                    byte_data,
    input  logic                          frame_end,
    output logic                          commit,
    output logic [N_ENTRY*ADDR_BYTES*8-1:0] staged
);
    localparam int ADDR_W    = ADDR_BYTES * 8;
    localparam int SETUP_LEN = N_ENTRY * GROUP_BYTES;
    localparam int SAT_CNT   = SETUP_LEN + 1;
    localparam int CNT_W     = $clog2(SAT_CNT + 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] byte_idx;
    logic [CNT_W-1:0] cnt_nxt;
    logic             live;
    logic             take;

    // Current byte offset, frame-open status and saturating next count.
    always_comb begin
        byte_idx = frame_start ? '0 : cnt_q;
        live     = frame_start | active_q;
        take     = live & byte_valid;
        if (take && (byte_idx < CNT_W'(SAT_CNT)))
            cnt_nxt = byte_idx + 1'b1;
        else
            cnt_nxt = byte_idx;
    end

    // Frame tracking and the delayed commit decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            commit   <= 1'b0;
        end else begin
            commit <= frame_end & live & (cnt_nxt == CNT_W'(SETUP_LEN));
            if (frame_end) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                active_q <= live;
                if (live)
                    cnt_q <= cnt_nxt;
            end
        end
    end

    // Steer each accepted byte into the staging slot its offset names.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= '0;
        end else if (take) begin
            for (int n = 0; n < N_ENTRY; n++) begin
                for (int k = 0; k < ADDR_BYTES; k++) begin
                    if (byte_idx == CNT_W'(n * GROUP_BYTES + int'(slot_offset(k))))
                        staged[n*ADDR_W + k*8 +: 8] <= byte_data;
                end
            end
        end
    end

endmodule

// File: rtl/daf_addr_table.sv
// Module: daf_addr_table
// Holds the perfect-match address table and compares one address against
// every entry in parallel, returning one hit bit per entry.
// Assumes: commit comes from the loader one cycle after the staged image is
// complete; the table resets to all zeros.
module daf_addr_table #(
    parameter int N_ENTRY    = 16,
    parameter int ADDR_BYTES = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            commit,
    input  logic [N_ENTRY*ADDR_BYTES*8-1:0] staged,
    input  logic [ADDR_BYTES*8-1:0]         lookup,
    output logic [N_ENTRY-1:0]              hit_vec,
    output logic [N_ENTRY*ADDR_BYTES*8-1:0] table_out
);
    localparam int ADDR_W = ADDR_BYTES * 8;

    logic [N_ENTRY*ADDR_W-1:0] tbl_q;

    // Replace the whole table at once when a complete frame commits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tbl_q <= '0;
        else if (commit)
            tbl_q <= staged;
    end

    // One equality comparator per entry.
    for (genvar e = 0; e < N_ENTRY; e++) begin : g_cmp
        assign hit_vec[e] = (lookup == tbl_q[e*ADDR_W +: ADDR_W]);
    end

    assign table_out = tbl_q;

endmodule

// File: rtl/daf_verdict.sv
// Module: daf_verdict
// Applies the ordered decision chain (broadcast, bypass modes, multicast,
// table match with optional inversion) and registers the verdict.
// Assumes: byte 0 of the address is in bits 7:0 and its bit 0 is the
// group (multicast) bit.
module daf_verdict
    import daf_pkg::*;
#(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    addr_valid,
    input  logic [ADDR_BYTES*8-1:0] addr,
    input  logic                    hit_any,
    input  daf_mode_t               mode,
    output logic                    valid_q,
    output daf_verdict_t            verdict_q
);
    daf_verdict_t verdict_d;

    // Ordered decision chain; earlier rules shadow later ones.
    always_comb begin
        verdict_d = '0;
        if (&addr) begin
            verdict_d.accept = 1'b1;
        end else if (mode.promisc | mode.rx_all) begin
            verdict_d.accept    = 1'b1;
            verdict_d.filt_fail = 1'b1;
        end else if (mode.all_multi & addr[0]) begin
            verdict_d.accept = 1'b1;
            verdict_d.mcast  = 1'b1;
        end else begin
            verdict_d.accept = hit_any ^ mode.inverse;
        end
    end

    // Register the verdict; idle cycles give an all-low verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            verdict_q <= '0;
        end else begin
            valid_q   <= addr_valid;
            verdict_q <= addr_valid ? verdict_d : '0;
        end
    end

endmodule

// File: rtl/dest_addr_filter.sv
// Module: dest_addr_filter (top)
// Destination-address filter: setup-frame loader, parallel match table and
// registered decision chain.
// Assumes: synchronous active-low reset; a lookup in the same cycle as a
// table commit sees the previous table.
module dest_addr_filter
    import daf_pkg::*;
#(
    parameter int N_ENTRY     = 16,
    parameter int ADDR_BYTES  = 6,
    parameter int GROUP_BYTES = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    setup_start,
    input  logic                    setup_valid,
    input  logic [7:0]              setup_data,
    input  logic                    setup_end,
    input  logic                    addr_valid,
    input  logic [ADDR_BYTES*8-1:0] addr,
    input  logic                    mode_promisc,
    input  logic                    mode_rx_all,
    input  logic                    mode_all_multi,
    input  logic                    mode_inverse,
    output logic                    result_valid,
    output logic                    accept,
    output logic                    filter_fail,
    output logic                    multicast_hit
);
    localparam int ADDR_W  = ADDR_BYTES * 8;
    localparam int TABLE_W = N_ENTRY * ADDR_W;

    logic               commit_pulse;
    logic [TABLE_W-1:0] staged_img;
    logic [TABLE_W-1:0] table_flat;
    logic [N_ENTRY-1:0] hit_vec;
    daf_mode_t          mode;
    daf_verdict_t       verdict;

    // Gather the mode inputs into one policy word.
    always_comb begin
        mode.promisc   = mode_promisc;
        mode.rx_all    = mode_rx_all;
        mode.all_multi = mode_all_multi;
        mode.inverse   = mode_inverse;
    end

    daf_setup_loader #(
        .N_ENTRY    (N_ENTRY),
        .ADDR_BYTES (ADDR_BYTES),
        .GROUP_BYTES(GROUP_BYTES)
    ) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(setup_start),
        .byte_valid (setup_valid),
        .byte_data  (setup_data),
        .frame_end  (setup_end),
        .commit     (commit_pulse),
        .staged     (staged_img)
    );

    daf_addr_table #(
        .N_ENTRY   (N_ENTRY),
        .ADDR_BYTES(ADDR_BYTES)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit_pulse),
        .staged   (staged_img),
        .lookup   (addr),
        .hit_vec  (hit_vec),
        .table_out(table_flat)
    );

    daf_verdict #(
        .ADDR_BYTES(ADDR_BYTES)
    ) u_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_valid(addr_valid),
        .addr      (addr),
        .hit_any   (|hit_vec),
        .mode      (mode),
        .valid_q   (result_valid),
        .verdict_q (verdict)
    );

    assign accept        = verdict.accept;
    assign filter_fail   = verdict.filt_fail;
    assign multicast_hit = verdict.mcast;

endmodule

// File: rtl/dest_addr_filter_chk.sv
// Module: dest_addr_filter_chk
// Concurrent checks on the filter's ports and its committed table, bound to
// every instance of dest_addr_filter.
// Assumes: observes only; drives nothing.
module dest_addr_filter_chk #(
    parameter int N_ENTRY    = 16,
    parameter int ADDR_BYTES = 6
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            setup_end,
    input logic                            addr_valid,
    input logic [ADDR_BYTES*8-1:0]         addr,
    input logic                            mode_promisc,
    input logic                            mode_rx_all,
    input logic                            mode_all_multi,
    input logic                            result_valid,
    input logic                            accept,
    input logic                            filter_fail,
    input logic                            multicast_hit,
    input logic                            commit_pulse,
    input logic [N_ENTRY*ADDR_BYTES*8-1:0] table_flat
);
    // Table only changes after a commit.
    p_table_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_pulse |=> $stable(table_flat));

    // A commit only follows an end strobe.
    p_commit_after_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |-> $past(setup_end));

    // Broadcast passes with no flag.
    p_broadcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && (&addr)) |=> (accept && !filter_fail && !multicast_hit));

    // Bypass modes pass and flag filtering failure.
    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !(&addr) && (mode_promisc || mode_rx_all))
        |=> (accept && filter_fail && !multicast_hit));

    // Multicast pass-through raises only the multicast flag.
    p_multicast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !(&addr) && !mode_promisc && !mode_rx_all && mode_all_multi && addr[0])
        |=> (accept && multicast_hit && !filter_fail));

    // Flags are exclusive and never appear on a rejected address.
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({filter_fail, multicast_hit}) && ((filter_fail || multicast_hit) -> accept));

    // Result follows address strobe by exactly one cycle.
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> result_valid);

    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> !result_valid);

    // Idle cycles show an all-low verdict.
    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> (!accept && !filter_fail && !multicast_hit));

endmodule

bind dest_addr_filter dest_addr_filter_chk #(
    .N_ENTRY   (N_ENTRY),
    .ADDR_BYTES(ADDR_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .setup_end     (setup_end),
    .addr_valid    (addr_valid),
    .addr          (addr),
    .mode_promisc  (mode_promisc),
    .mode_rx_all   (mode_rx_all),
    .mode_all_multi(mode_all_multi),
    .result_valid  (result_valid),
    .accept        (accept),
    .filter_fail   (filter_fail),
    .multicast_hit (multicast_hit),
    .commit_pulse  (commit_pulse),
    .table_flat    (table_flat)
);

// File: tb/dest_addr_filter_tb.sv
`timescale 1ns/1ps
// Bench: sweeps every stored address, a neighbour of it, filler-built and
// special addresses under all sixteen mode combinations, after each kind of
// setup-frame load, against an arithmetic model of the table and chain.
module dest_addr_filter_tb;
    localparam int NE = 16;
    localparam int GB = 12;
    localparam int FRAME = NE * GB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_start = 1'b0, setup_valid = 1'b0, setup_end = 1'b0;
    logic [7:0]  setup_data = '0;
    logic        addr_valid = 1'b0;
    logic [47:0] addr = '0;
    logic        mode_promisc = 1'b0, mode_rx_all = 1'b0;
    logic        mode_all_multi = 1'b0, mode_inverse = 1'b0;
    logic        result_valid, accept, filter_fail, multicast_hit;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;
    logic [47:0] model_tab [NE];

    always #2.5 clk = ~clk;

    dest_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n),
        .setup_start(setup_start), .setup_valid(setup_valid),
        .setup_data(setup_data), .setup_end(setup_end),
        .addr_valid(addr_valid), .addr(addr),
        .mode_promisc(mode_promisc), .mode_rx_all(mode_rx_all),
        .mode_all_multi(mode_all_multi), .mode_inverse(mode_inverse),
        .result_valid(result_valid), .accept(accept),
        .filter_fail(filter_fail), .multicast_hit(multicast_hit)
    );

    // Setup-frame byte at offset o for a pattern seed; used and filler slots differ.
    function automatic logic [7:0] gen_byte(input int seed, input int o);
        int r = o % GB;
        if (r == 0 || r == 1 || r == 4 || r == 5 || r == 8 || r == 9)
            return 8'((o * 13 + seed * 71 + 3) & 255);
        return 8'(((o * 5) ^ 8'h5a ^ seed) & 255);
    endfunction

    // Address of entry n as the requirement lays it out (R2).
    function automatic logic [47:0] entry_of(input int seed, input int n);
        logic [47:0] a;
        int offs [6] = '{0, 1, 4, 5, 8, 9};
        for (int k = 0; k < 6; k++) a[k*8 +: 8] = gen_byte(seed, n * GB + offs[k]);
        return a;
    endfunction

    // Address built from the six unused slots of group n.
    function automatic logic [47:0] filler_of(input int seed, input int n);
        logic [47:0] a;
        int offs [6] = '{2, 3, 6, 7, 10, 11};
        for (int k = 0; k < 6; k++) a[k*8 +: 8] = gen_byte(seed, n * GB + offs[k]);
        return a;
    endfunction

    // Expected {valid, accept, filter_fail, multicast} (R5..R8).
    function automatic logic [3:0] expect_of(input logic [47:0] a, input logic [3:0] m);
        logic hit = 1'b0;
        for (int i = 0; i < NE; i++) if (model_tab[i] == a) hit = 1'b1;
        if (&a)                 return 4'b1100;
        if (m[3] | m[2])        return 4'b1110;
        if (m[1] & a[0])        return 4'b1101;
        return {1'b1, hit ^ m[0], 2'b00};
    endfunction

    task automatic check(input logic [3:0] act, input logic [3:0] exp_v, input string req);
        vectors++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s addr=%h modes=%b actual=%b expected=%b", req, addr,
                     {mode_promisc, mode_rx_all, mode_all_multi, mode_inverse}, act, exp_v);
        end
    endtask

    // Present one address under modes m={promisc,rx_all,all_multi,inverse}.
    task automatic present(input logic [47:0] a, input logic [3:0] m, input string req);
        logic [3:0] e;
        addr = a; addr_valid = 1'b1;
        {mode_promisc, mode_rx_all, mode_all_multi, mode_inverse} = m;
        e = expect_of(a, m);
        @(negedge clk);
        check({result_valid, accept, filter_fail, multicast_hit}, e, req);
        addr_valid = 1'b0;
    endtask

    // Stream a setup frame of len bytes; optionally without a start strobe.
    task automatic load(input int seed, input int len, input bit with_start);
        for (int i = 0; i < len; i++) begin
            setup_start = with_start && (i == 0);
            setup_valid = 1'b1;
            setup_data  = gen_byte(seed, i);
            setup_end   = (i == len - 1);
            @(negedge clk);
        end
        setup_start = 1'b0; setup_valid = 1'b0; setup_end = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (with_start && len == FRAME)
            for (int n = 0; n < NE; n++) model_tab[n] = entry_of(seed, n);
    endtask

    // Full sweep of stored, neighbour, filler and special addresses.
    task automatic sweep(input int seed, input string req);
        for (int m = 0; m < 16; m++) begin
            for (int n = 0; n < NE; n++) begin
                present(entry_of(seed, n), 4'(m), req);
                present(entry_of(seed, n) ^ 48'h0100_0000_0000, 4'(m), "R8");
                present(filler_of(seed, n), 4'(m), "R2");
            end
            present(48'hffff_ffff_ffff, 4'(m), "R5");
            present(48'h0000_0000_0013, 4'(m), "R7");
            present(48'h0000_0000_0042, 4'(m), "R6");
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < NE; n++) model_tab[n] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: idle outputs after reset.
        check({result_valid, accept, filter_fail, multicast_hit}, 4'b0000, "R9");
        // R1: zeroed table matches only the zero address.
        present(48'h0, 4'b0000, "R1");
        present(48'h0000_0000_0010, 4'b0000, "R1");
        present(48'h0, 4'b0001, "R1");
        // R2: full load, then sweep every mode.
        load(1, FRAME, 1'b1);
        sweep(1, "R2");
        // R9: no result the cycle after an idle strobe.
        @(negedge clk);
        check({result_valid, accept, filter_fail, multicast_hit}, 4'b0000, "R9");
        // R3: short and long frames leave table from seed 1.
        load(2, FRAME - 1, 1'b1);
        for (int n = 0; n < NE; n++) present(entry_of(1, n), 4'b0000, "R3");
        load(3, FRAME + 1, 1'b1);
        for (int n = 0; n < NE; n++) present(entry_of(1, n), 4'b0000, "R3");
        present(entry_of(3, 5), 4'b0000, "R3");
        // R4: unframed bytes and end strobe are ignored.
        load(4, FRAME, 1'b0);
        for (int n = 0; n < NE; n++) present(entry_of(1, n), 4'b0000, "R4");
        present(entry_of(4, 7), 4'b0000, "R4");
        // R4: a start mid-frame restarts the count.
        for (int i = 0; i < 50; i++) begin
            setup_start = (i == 0); setup_valid = 1'b1; setup_data = gen_byte(6, i);
            @(negedge clk);
        end
        setup_valid = 1'b0;
        load(5, FRAME, 1'b1);
        for (int n = 0; n < NE; n++) present(entry_of(5, n), 4'b0000, "R4");
        sweep(5, "R8");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule